// File: doc/BRIEF.md
# Accumulator Processor Sequencer

This block is the hardwired sequencer of a small 8-bit accumulator processor. It is a Moore state machine with thirteen one-cycle states. It reads the opcode held in the instruction register and the zero flag. In every state it raises a fixed pattern of strobes for the rest of the processor: memory read and write, the address source select, register loads, bus output enables, the ALU operation code and the status-register controls.

Each instruction starts with a fetch cycle and then a decode cycle. Register and immediate arithmetic take two more cycles. Load, store and jump take three more: two address-byte reads and one final access. A conditional jump on zero whose flag is clear ends at decode. A synchronous reset puts the machine back at fetch. Any strobe a state does not name stays low.

Top module: `acc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is fetch. In the first cycle after reset, the outputs show the fetch pattern.
- R2: Fetch raises `mem_rd`, `ir_ld` and `pc_ld` with `addr_sel` = 00 (program counter). The state after fetch is always decode.
- R3: In decode every output is 0. Opcode 72h with `zero_in` = 0 goes back to fetch. So does every opcode outside {18h, 20h, 24h, 30h, 35h, 36h, 68h, 69h, 70h, 71h, 72h, 74h}.
- R4: Opcodes 30h, 18h, 20h and 24h go from decode to a cycle that raises `rb_rd` and `tmp_ld` with `rb_sel` = 00.
- R5: Opcodes 35h, 36h, 68h and 69h go from decode to a cycle that raises `mem_rd`, `tmp_ld` and `pc_ld` with `addr_sel` = 00.
- R6: After the operand cycle comes one ALU cycle. It raises `alu_oe`, `acc_ld` and `flags_ld`, with `ovf_sel`, `carry_sel` and `zero_sel` all 0. `alu_op` is 000 for 30h/35h, 001 for 18h/36h, 010 for 20h/68h and 011 for 24h/69h. Fetch follows.
- R7: Opcodes 70h, 71h and 74h, and 72h with `zero_in` = 1, go from decode to two address cycles. Both raise `mem_rd` and `pc_ld` with `addr_sel` = 00. The first raises `hl_lo_ld` and the second raises `hl_hi_ld`.
- R8: For 70h the third cycle raises `mem_rd` and `acc_ld` with `addr_sel` = 10 (HL). Fetch follows.
- R9: For 71h the third cycle raises `mem_wr` and `acc_oe` with `addr_sel` = 10. Fetch follows.
- R10: For 74h, and for 72h when taken, the third cycle raises `pc_ld` with `addr_sel` = 10. Fetch follows.
- R11: `zero_in` changes the sequence only for opcode 72h in decode. Every other opcode runs the same cycles whatever its value.
- R12: At most one of `mem_rd`, `rb_rd`, `alu_oe`, `acc_oe` and `flags_oe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Instruction register contents |
| zero_in | input | 1 | Zero flag from the status register |
| mem_rd | output | 1 | Memory drives the data bus |
| mem_wr | output | 1 | Memory stores the data bus |
| addr_sel | output | 2 | Address source: 00 PC, 01 SP, 10 HL |
| ir_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Program counter load |
| hl_lo_ld | output | 1 | Low address byte load |
| hl_hi_ld | output | 1 | High address byte load |
| acc_ld | output | 1 | Accumulator load |
| acc_oe | output | 1 | Accumulator drives the bus |
| tmp_ld | output | 1 | Temporary register load |
| rb_rd | output | 1 | Register bank drives the bus |
| rb_wr | output | 1 | Register bank load (held 0) |
| rb_sel | output | 2 | Register bank entry select |
| alu_op | output | 3 | ALU operation code |
| alu_oe | output | 1 | ALU result drives the bus |
| flags_ld | output | 1 | Status register load |
| flags_oe | output | 1 | Status register drives the bus (held 0) |
| ovf_sel | output | 1 | Overflow flag source, 0 = ALU |
| carry_sel | output | 1 | Carry flag source, 0 = ALU |
| zero_sel | output | 1 | Zero flag source, 0 = ALU |

## Verification
Every output is decoded from the state register alone. A strobe therefore changes one rising edge after the cycle whose inputs chose it, and stays steady for the whole next cycle. The driver holds opcode and flag for one whole instruction. It queues the pattern expected for each cycle of that instruction: two to five patterns, depending on the path the requirements give. The monitor pops one pattern per cycle, two time units after each falling edge, so every comparison falls mid-cycle, one edge after the decision. The test also applies reset part-way through an address read and expects the fetch pattern in the first cycle afterwards.

// File: rtl/acc_sequencer.sv
module acc_sequencer #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           zero_in,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [1:0]     addr_sel,
  output logic           ir_ld,
  output logic           pc_ld,
  output logic           hl_lo_ld,
  output logic           hl_hi_ld,
  output logic           acc_ld,
  output logic           acc_oe,
  output logic           tmp_ld,
  output logic           rb_rd,
  output logic           rb_wr,
  output logic [1:0]     rb_sel,
  output logic [2:0]     alu_op,
  output logic           alu_oe,
  output logic           flags_ld,
  output logic           flags_oe,
  output logic           ovf_sel,
  output logic           carry_sel,
  output logic           zero_sel
);

  localparam logic [OPW-1:0] OP_ADD = OPW'('h30);
  localparam logic [OPW-1:0] OP_SUB = OPW'('h18);
  localparam logic [OPW-1:0] OP_ANA = OPW'('h20);
  localparam logic [OPW-1:0] OP_ORA = OPW'('h24);
  localparam logic [OPW-1:0] OP_ADI = OPW'('h35);
  localparam logic [OPW-1:0] OP_SUI = OPW'('h36);
  localparam logic [OPW-1:0] OP_ANI = OPW'('h68);
  localparam logic [OPW-1:0] OP_ORI = OPW'('h69);
  localparam logic [OPW-1:0] OP_LDA = OPW'('h70);
  localparam logic [OPW-1:0] OP_STA = OPW'('h71);
  localparam logic [OPW-1:0] OP_JZ  = OPW'('h72);
  localparam logic [OPW-1:0] OP_JMP = OPW'('h74);

  typedef enum logic [3:0] {
    ST_FETCH = 4'd0,  ST_DEC   = 4'd1,  ST_REGOP = 4'd2,  ST_IMMOP = 4'd3,
    ST_ADD   = 4'd4,  ST_SUB   = 4'd5,  ST_AND   = 4'd6,  ST_OR    = 4'd7,
    ST_ADRL  = 4'd8,  ST_ADRH  = 4'd9,  ST_LOAD  = 4'd10, ST_STORE = 4'd11,
    ST_JUMP  = 4'd12
  } st_t;

  st_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_FETCH;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx = ST_FETCH;
    unique case (st)
      ST_FETCH: st_nx = ST_DEC;
      ST_DEC: begin
        case (opcode)
          OP_ADD, OP_SUB, OP_ANA, OP_ORA: st_nx = ST_REGOP;
          OP_ADI, OP_SUI, OP_ANI, OP_ORI: st_nx = ST_IMMOP;
          OP_LDA, OP_STA, OP_JMP:         st_nx = ST_ADRL;
          OP_JZ:   st_nx = zero_in ? ST_ADRL : ST_FETCH;
          default: st_nx = ST_FETCH;
        endcase
      end
      ST_REGOP, ST_IMMOP: begin
        case (opcode)
          OP_ADD, OP_ADI: st_nx = ST_ADD;
          OP_SUB, OP_SUI: st_nx = ST_SUB;
          OP_ANA, OP_ANI: st_nx = ST_AND;
          OP_ORA, OP_ORI: st_nx = ST_OR;
          default:        st_nx = ST_FETCH;
        endcase
      end
      ST_ADRL: st_nx = ST_ADRH;
      ST_ADRH: begin
        case (opcode)
          OP_LDA:         st_nx = ST_LOAD;
          OP_STA:         st_nx = ST_STORE;
          OP_JZ, OP_JMP:  st_nx = ST_JUMP;
          default:        st_nx = ST_FETCH;
        endcase
      end
      default: st_nx = ST_FETCH;
    endcase
  end

  logic in_alu, pc_src, hl_src;
  assign in_alu = (st == ST_ADD) || (st == ST_SUB) || (st == ST_AND) || (st == ST_OR);
  assign pc_src = (st == ST_FETCH) || (st == ST_IMMOP) || (st == ST_ADRL) || (st == ST_ADRH);
  assign hl_src = (st == ST_LOAD) || (st == ST_STORE) || (st == ST_JUMP);

  assign addr_sel  = hl_src ? 2'b10 : 2'b00;
  assign mem_rd    = pc_src || (st == ST_LOAD);
  assign mem_wr    = (st == ST_STORE);
  assign ir_ld     = (st == ST_FETCH);
  assign pc_ld     = pc_src || (st == ST_JUMP);
  assign hl_lo_ld  = (st == ST_ADRL);
  assign hl_hi_ld  = (st == ST_ADRH);
  assign acc_ld    = in_alu || (st == ST_LOAD);
  assign acc_oe    = (st == ST_STORE);
  assign tmp_ld    = (st == ST_REGOP) || (st == ST_IMMOP);
  assign rb_rd     = (st == ST_REGOP);
  assign rb_wr     = 1'b0;
  assign rb_sel    = 2'b00;
  assign alu_op    = in_alu ? (st[2:0] - 3'd4) : 3'b000;
  assign alu_oe    = in_alu;
  assign flags_ld  = in_alu;
  assign flags_oe  = 1'b0;
  assign ovf_sel   = 1'b0;
  assign carry_sel = 1'b0;
  assign zero_sel  = 1'b0;

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> !(mem_rd || mem_wr || pc_ld || ir_ld || tmp_ld || acc_ld || hl_lo_ld || hl_hi_ld));

  // R3
  jz_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEC && opcode == OP_JZ && !zero_in) |=> ir_ld);

  // R6
  alu_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    alu_oe |=> ir_ld);

  // R7
  low_then_high_chk: assert property (@(posedge clk) disable iff (rst)
    hl_lo_ld |=> hl_hi_ld);

  // R10
  hl_access_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_sel == 2'b10) |=> ir_ld);

  // R12
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, rb_rd, alu_oe, acc_oe, flags_oe}));

endmodule

// File: tb/acc_sequencer_bench.sv
`timescale 1ns/1ps
module acc_sequencer_bench;
  logic clk = 1'b0, rst = 1'b1, zero_in = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic mem_rd, mem_wr, ir_ld, pc_ld, hl_lo_ld, hl_hi_ld, acc_ld, acc_oe, tmp_ld;
  logic rb_rd, rb_wr, alu_oe, flags_ld, flags_oe, ovf_sel, carry_sel, zero_sel;
  logic [1:0] addr_sel, rb_sel;
  logic [2:0] alu_op;

  always #4 clk = ~clk;

  acc_sequencer u_acc_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .zero_in(zero_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_ld(ir_ld),
    .pc_ld(pc_ld), .hl_lo_ld(hl_lo_ld), .hl_hi_ld(hl_hi_ld), .acc_ld(acc_ld),
    .acc_oe(acc_oe), .tmp_ld(tmp_ld), .rb_rd(rb_rd), .rb_wr(rb_wr), .rb_sel(rb_sel),
    .alu_op(alu_op), .alu_oe(alu_oe), .flags_ld(flags_ld), .flags_oe(flags_oe),
    .ovf_sel(ovf_sel), .carry_sel(carry_sel), .zero_sel(zero_sel)
  );

  typedef struct { logic [24:0] vec; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit after_rst = 1'b0;

  // field order: mem_rd mem_wr addr_sel ir_ld pc_ld hl_lo hl_hi acc_ld acc_oe tmp_ld
  //              rb_rd rb_wr rb_sel alu_op alu_oe flags_ld flags_oe ovf carry zero
  function automatic logic [24:0] pack(bit mr, bit mw, logic [1:0] as, bit ir, bit pc,
      bit lo, bit hi, bit al, bit ao, bit tl, bit rr, logic [2:0] op, bit aoe, bit fl);
    return {mr, mw, as, ir, pc, lo, hi, al, ao, tl, rr, 1'b0, 2'b00, op, aoe, fl, 1'b0, 3'b000};
  endfunction

  function automatic logic [24:0] expect_of(int s);
    case (s)
      0:  return pack(1,0,2'b00,1,1,0,0,0,0,0,0,3'd0,0,0);
      2:  return pack(0,0,2'b00,0,0,0,0,0,0,1,1,3'd0,0,0);
      3:  return pack(1,0,2'b00,0,1,0,0,0,0,1,0,3'd0,0,0);
      4,5,6,7: return pack(0,0,2'b00,0,0,0,0,1,0,0,0,3'(s-4),1,1);
      8:  return pack(1,0,2'b00,0,1,1,0,0,0,0,0,3'd0,0,0);
      9:  return pack(1,0,2'b00,0,1,0,1,0,0,0,0,3'd0,0,0);
      10: return pack(1,0,2'b10,0,0,0,0,1,0,0,0,3'd0,0,0);
      11: return pack(0,1,2'b10,0,0,0,0,0,1,0,0,3'd0,0,0);
      12: return pack(0,0,2'b10,0,1,0,0,0,0,0,0,3'd0,0,0);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      8, 9: return "R7"; 10: return "R8"; 11: return "R9"; 12: return "R10";
      default: return "R6";
    endcase
  endfunction

  function automatic int alu_state(logic [7:0] op);
    case (op)
      8'h30, 8'h35: return 4;
      8'h18, 8'h36: return 5;
      8'h20, 8'h68: return 6;
      default:      return 7;
    endcase
  endfunction

  task automatic run_instr(logic [7:0] op, bit z, string note, int cut = 0);
    int path[$];
    path.push_back(0); path.push_back(1);
    case (op)
      8'h30, 8'h18, 8'h20, 8'h24: begin path.push_back(2); path.push_back(alu_state(op)); end
      8'h35, 8'h36, 8'h68, 8'h69: begin path.push_back(3); path.push_back(alu_state(op)); end
      8'h70, 8'h71, 8'h74, 8'h72: if (op != 8'h72 || z) begin
        path.push_back(8); path.push_back(9);
        path.push_back(op == 8'h70 ? 10 : (op == 8'h71 ? 11 : 12));
      end
      default: ;
    endcase
    if (cut > 0) while (path.size() > cut) void'(path.pop_back());
    opcode = op; zero_in = z;
    foreach (path[i]) begin
      item_t it;
      it.vec = expect_of(path[i]);
      it.tag = (i == 0 && after_rst) ? "R1" : {tag_of(path[i]), " ", note};
      sb.push_back(it);
    end
    after_rst = 1'b0;
    repeat (path.size()) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    after_rst = 1'b1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [24:0] got;
        it = sb.pop_front();
        got = {mem_rd, mem_wr, addr_sel, ir_ld, pc_ld, hl_lo_ld, hl_hi_ld, acc_ld, acc_oe,
               tmp_ld, rb_rd, rb_wr, rb_sel, alu_op, alu_oe, flags_ld, flags_oe,
               ovf_sel, carry_sel, zero_sel};
        checks++;
        if (got !== it.vec) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.vec);
        end
        checks++;
        if ($countones({mem_rd, rb_rd, alu_oe, acc_oe, flags_oe}) > 1) begin
          fails++;
          $display("FAIL R12: bus drivers %b expected at most one high",
                   {mem_rd, rb_rd, alu_oe, acc_oe, flags_oe});
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(8ns * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin : driver
    @(negedge clk);
    do_reset();
    run_instr(8'h30, 0, "add");
    run_instr(8'h18, 0, "sub");
    run_instr(8'h20, 0, "ana");
    run_instr(8'h24, 0, "ora");
    run_instr(8'h35, 0, "adi");
    run_instr(8'h36, 0, "sui");
    run_instr(8'h68, 0, "ani");
    run_instr(8'h69, 0, "ori");
    run_instr(8'h70, 0, "lda");
    run_instr(8'h71, 0, "sta");
    run_instr(8'h74, 0, "jmp z=0 R11");
    run_instr(8'h72, 1, "jz taken");
    run_instr(8'h72, 0, "jz not taken");
    run_instr(8'h00, 0, "unknown 00");
    run_instr(8'hFF, 1, "unknown FF");
    run_instr(8'h31, 0, "unmapped 31");
    // R11: flag set must not alter non-jump paths
    run_instr(8'h30, 1, "add z=1 R11");
    run_instr(8'h69, 1, "ori z=1 R11");
    run_instr(8'h71, 1, "sta z=1 R11");
    // R1: reset during an address cycle
    run_instr(8'h70, 0, "lda cut", 3);
    do_reset();
    run_instr(8'h24, 0, "ora after reset");
    run_instr(8'h72, 1, "jz taken again");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    finish_run();
  end
endmodule